// File: doc/BRIEF.md
# Power-Manager Interrupt Status Aggregator

This block collects wake and voltage-transition events for a power-management unit and presents them to the processor as one interrupt line. Four event pulse inputs latch sticky bits in two 32-bit status words: an I/O wake event and a transaction-done event for each of three voltage domains (processor, accelerator, core). Each status word has a 32-bit enable word. The interrupt is raised whenever any status bit is set together with its enable bit, in either word.

Software reaches the words over a simple register bus with a word address, a write strobe, write data and registered read data. Status bits are acknowledged by writing ones to them. The enable words are plain read/write masks, so a handler can save them, write zero to silence the line, and later restore them. A constant revision word can be read to confirm that every earlier write has landed, because a read returns state that already includes all writes issued in earlier cycles.

Top module: `pmIrqAggregator`

## Requirements
- R1: After reset both status words and both enable words read 0, the interrupt output is low and the read data is 0.
- R2: A high event input sets its status bit on the next clock edge, and the bit stays set after the input falls. I/O wake maps to status word 0 bit 9, accelerator-domain done to word 0 bit 2, core-domain done to word 0 bit 3, processor-domain done to word 1 bit 0. All other status bits always read 0.
- R3: A write to a status word clears each bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R4: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable words hold all 32 written bits and read them back unchanged.
- R6: The interrupt output is the OR over both words of (status AND enable), registered: it reflects the register state one cycle after any status or enable update.
- R7: With both enable words at 0 the interrupt stays low, whatever status bits are pending.
- R8: Writing a nonzero enable value that covers a pending status bit raises the interrupt one cycle after the write takes effect.
- R9: Byte address 0x10 reads the constant 0x0001_0200. Read data appears one cycle after the address and already includes every write from earlier cycles, so a read issued the cycle after a write sees its effect.
- R10: The register addresses are status words at byte offsets 0x00 and 0x04, enable words at 0x08 and 0x0C, revision at 0x10. Any other address reads 0, and writes to it or to the revision word change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe for the current cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data for the address of the previous cycle |
| evIoWake | input | 1 | I/O wake event pulse |
| evDoneProc | input | 1 | Processor-domain transaction-done pulse |
| evDoneAccel | input | 1 | Accelerator-domain transaction-done pulse |
| evDoneCore | input | 1 | Core-domain transaction-done pulse |
| irqOut | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions assume that every input is a known 0 or 1 once reset is released and holds still for the whole cycle. The clear check assumes that the I/O wake input is not pulsing in the cycle of the acknowledging write, and the stability check assumes that no event arrives in the cycle of a write to the revision or an unused address. The bench changes its inputs only on the falling edge. Its directed cases keep event inputs low where those properties need it. Its random phase mixes reads, writes and event pulses freely, because the antecedents of the properties screen out the cycles that fall outside their assumptions.

// File: rtl/pmIrqPkg.sv
package pmIrqPkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int NREG = 2;
  localparam int REG_STRIDE = 4;
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  localparam logic [ADDR_W-1:0] OFS_STAT_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EN_BASE = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_REV = 8'h10;
  localparam logic [DATA_W-1:0] REVISION = 32'h0001_0200;

  // Source bit positions; software decodes these, so they are fixed.
  localparam int BIT_IO_WAKE = 9;
  localparam int BIT_DONE_ACCEL = 2;
  localparam int BIT_DONE_CORE = 3;
  localparam int BIT_DONE_PROC = 0;

  localparam logic [DATA_W-1:0] LIVE_MASK0 =
    (DATA_W'(1) << BIT_IO_WAKE) | (DATA_W'(1) << BIT_DONE_ACCEL) | (DATA_W'(1) << BIT_DONE_CORE);
  localparam logic [DATA_W-1:0] LIVE_MASK1 = DATA_W'(1) << BIT_DONE_PROC;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_EN,
    SEL_REV
  } rdSel_e;

  typedef struct packed {
    logic [NREG-1:0] clrStat;
    logic [NREG-1:0] loadEn;
    logic [DATA_W-1:0] wrData;
    rdSel_e rdSel;
    logic [IDX_W-1:0] rdIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/pmIrqCtrl.sv
module pmIrqCtrl
  import pmIrqPkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output ctlStrobes_t       strb
);
  always_comb begin
    strb = '0;
    strb.wrData = regWrData;
    strb.rdSel = SEL_NONE;
    for (int i = 0; i < NREG; i++) begin
      if (regAddr == ADDR_W'(int'(OFS_STAT_BASE) + i * REG_STRIDE)) begin
        strb.rdSel = SEL_STAT;
        strb.rdIdx = IDX_W'(i);
        strb.clrStat[i] = regWrEn;
      end
      if (regAddr == ADDR_W'(int'(OFS_EN_BASE) + i * REG_STRIDE)) begin
        strb.rdSel = SEL_EN;
        strb.rdIdx = IDX_W'(i);
        strb.loadEn[i] = regWrEn;
      end
    end
    if (regAddr == OFS_REV) begin
      strb.rdSel = SEL_REV;
    end
  end
endmodule

// File: rtl/pmIrqDatapath.sv
module pmIrqDatapath
  import pmIrqPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  strb,
  input  logic                         evIoWake,
  input  logic                         evDoneProc,
  input  logic                         evDoneAccel,
  input  logic                         evDoneCore,
  output logic [NREG-1:0][DATA_W-1:0]  statusQ,
  output logic [NREG-1:0][DATA_W-1:0]  enableQ,
  output logic [DATA_W-1:0]            rdData,
  output logic                         irqOut
);
  logic [NREG-1:0][DATA_W-1:0] setVec;
  logic [NREG-1:0][DATA_W-1:0] pending;

  always_comb begin
    setVec = '0;
    setVec[0][BIT_IO_WAKE] = evIoWake;
    setVec[0][BIT_DONE_ACCEL] = evDoneAccel;
    setVec[0][BIT_DONE_CORE] = evDoneCore;
    setVec[1][BIT_DONE_PROC] = evDoneProc;
  end

  for (genvar g = 0; g < NREG; g++) begin : gWord
    logic [DATA_W-1:0] clrMask;
    assign clrMask = strb.clrStat[g] ? strb.wrData : '0;
    assign pending[g] = statusQ[g] & enableQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ[g] <= '0;
        enableQ[g] <= '0;
      end else begin
        // set term applied after the clear so a simultaneous event wins
        statusQ[g] <= (statusQ[g] & ~clrMask) | setVec[g];
        if (strb.loadEn[g]) begin
          enableQ[g] <= strb.wrData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      rdData <= '0;
    end else begin
      irqOut <= |pending;
      case (strb.rdSel)
        SEL_STAT: rdData <= statusQ[strb.rdIdx];
        SEL_EN:   rdData <= enableQ[strb.rdIdx];
        SEL_REV:  rdData <= REVISION;
        default:  rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pmIrqAggregator.sv
module pmIrqAggregator
  import pmIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evIoWake,
  input  logic              evDoneProc,
  input  logic              evDoneAccel,
  input  logic              evDoneCore,
  output logic              irqOut
);
  ctlStrobes_t strb;
  logic [NREG-1:0][DATA_W-1:0] statusQ;
  logic [NREG-1:0][DATA_W-1:0] enableQ;

  pmIrqCtrl i_ctrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strb     (strb)
  );

  pmIrqDatapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .evIoWake   (evIoWake),
    .evDoneProc (evDoneProc),
    .evDoneAccel(evDoneAccel),
    .evDoneCore (evDoneCore),
    .statusQ    (statusQ),
    .enableQ    (enableQ),
    .rdData     (regRdData),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/pmIrqChecker.sv
module pmIrqChecker
  import pmIrqPkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            regAddr,
  input logic                         regWrEn,
  input logic [DATA_W-1:0]            regWrData,
  input logic [DATA_W-1:0]            regRdData,
  input logic                         evIoWake,
  input logic                         evDoneProc,
  input logic                         evDoneAccel,
  input logic                         evDoneCore,
  input logic                         irqOut,
  input logic [NREG-1:0][DATA_W-1:0]  statusQ,
  input logic [NREG-1:0][DATA_W-1:0]  enableQ
);
  logic pendAny;
  logic anyEvent;
  logic enAllZero;

  always_comb begin
    pendAny = 1'b0;
    enAllZero = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      pendAny = pendAny | (|(statusQ[i] & enableQ[i]));
      enAllZero = enAllZero & (enableQ[i] == '0);
    end
  end
  assign anyEvent = evIoWake | evDoneProc | evDoneAccel | evDoneCore;

  p_irq_follows_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(pendAny));

  p_event_sets_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    evIoWake |=> statusQ[0][BIT_IO_WAKE]);

  p_proc_done_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    evDoneProc |=> statusQ[1][BIT_DONE_PROC]);

  p_unused_bits_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ[0] & ~LIVE_MASK0) == '0) && ((statusQ[1] & ~LIVE_MASK1) == '0));

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_STAT_BASE && regWrData[BIT_IO_WAKE] && !evIoWake)
    |=> !statusQ[0][BIT_IO_WAKE]);

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    enAllZero |=> !irqOut);

  p_revision_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFS_REV) |=> regRdData == REVISION);

  p_rev_write_inert_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_REV && !anyEvent) |=> ($stable(statusQ) && $stable(enableQ)));
endmodule

bind pmIrqAggregator pmIrqChecker i_pmIrqChecker (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .evIoWake   (evIoWake),
  .evDoneProc (evDoneProc),
  .evDoneAccel(evDoneAccel),
  .evDoneCore (evDoneCore),
  .irqOut     (irqOut),
  .statusQ    (statusQ),
  .enableQ    (enableQ)
);

// File: tb/test_pmIrqAggregator.sv
`timescale 1ns/1ps
module test_pmIrqAggregator;
  import pmIrqPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic evIoWake = 1'b0;
  logic evDoneProc = 1'b0;
  logic evDoneAccel = 1'b0;
  logic evDoneCore = 1'b0;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] mStat [NREG];
  logic [DATA_W-1:0] mEn [NREG];

  localparam logic [7:0] A_ST0 = 8'h00, A_ST1 = 8'h04, A_EN0 = 8'h08, A_EN1 = 8'h0C;
  localparam logic [7:0] A_REV = 8'h10, A_NONE = 8'h14, A_ODD = 8'h02;
  // event vector order: {core, accel, proc, ioWake}
  localparam logic [3:0] EV_NONE = 4'b0000, EV_IO = 4'b0001, EV_PROC = 4'b0010;
  localparam logic [3:0] EV_ACCEL = 4'b0100, EV_CORE = 4'b1000;

  always #2 clk = ~clk;

  pmIrqAggregator i_pmIrqAggregator (
    .clk, .rstN, .regAddr, .regWrEn, .regWrData, .regRdData,
    .evIoWake, .evDoneProc, .evDoneAccel, .evDoneCore, .irqOut
  );

  function automatic logic [DATA_W-1:0] modelRead(input logic [7:0] a);
    case (a)
      A_ST0: return mStat[0];
      A_ST1: return mStat[1];
      A_EN0: return mEn[0];
      A_EN1: return mEn[1];
      A_REV: return 32'h0001_0200;
      default: return '0;
    endcase
  endfunction

  function automatic logic modelIrq();
    return |((mStat[0] & mEn[0]) | (mStat[1] & mEn[1]));
  endfunction

  function automatic logic [DATA_W-1:0] setBits(input int w, input logic [3:0] ev);
    logic [DATA_W-1:0] s = '0;
    if (w == 0) begin
      s[9] = ev[0];
      s[2] = ev[2];
      s[3] = ev[3];
    end else begin
      s[0] = ev[1];
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic w, input logic [DATA_W-1:0] d,
                      input logic [3:0] ev, input string req);
    logic [DATA_W-1:0] expRd;
    logic expIrq;
    @(negedge clk);
    regAddr = a;
    regWrEn = w;
    regWrData = d;
    {evDoneCore, evDoneAccel, evDoneProc, evIoWake} = ev;
    @(posedge clk);
    #1;
    expRd = modelRead(a);
    expIrq = modelIrq();
    for (int i = 0; i < NREG; i++) begin
      logic [DATA_W-1:0] clr;
      clr = (w && a == 8'(i * 4)) ? d : '0;
      mStat[i] = (mStat[i] & ~clr) | setBits(i, ev);
      if (w && a == 8'(8 + i * 4)) mEn[i] = d;
    end
    chk(req, regRdData, expRd);
    chk("R6", {31'b0, irqOut}, {31'b0, expIrq});
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin
      mStat[i] = '0;
      mEn[i] = '0;
    end
    void'($urandom(32'd24680));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {31'b0, irqOut}, 32'd0);
    chk("R1", regRdData, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: everything reads zero after reset
    step(A_ST0, 0, 0, EV_NONE, "R1");
    step(A_ST1, 0, 0, EV_NONE, "R1");
    step(A_EN0, 0, 0, EV_NONE, "R1");
    step(A_EN1, 0, 0, EV_NONE, "R1");
    chk("R1", regRdData, 32'd0);

    // R2: each event sets its own bit and it stays latched
    step(A_NONE, 0, 0, EV_IO, "R10");
    step(A_NONE, 0, 0, EV_NONE, "R10");
    step(A_ST0, 0, 0, EV_NONE, "R2");
    chk("R2", regRdData, 32'h0000_0200);
    step(A_NONE, 0, 0, EV_ACCEL | EV_CORE, "R10");
    step(A_ST0, 0, 0, EV_PROC, "R2");
    chk("R2", regRdData, 32'h0000_020C);
    step(A_ST1, 0, 0, EV_NONE, "R2");
    chk("R2", regRdData, 32'h0000_0001);

    // R7: pending status but enables zero keeps the line low
    step(A_NONE, 0, 0, EV_NONE, "R7");
    chk("R7", {31'b0, irqOut}, 32'd0);

    // R8: restore a mask covering pending bit 9
    step(A_EN0, 1, 32'hFFFF_FFFF, EV_NONE, "R5");
    chk("R8", {31'b0, irqOut}, 32'd0);
    step(A_NONE, 0, 0, EV_NONE, "R8");
    chk("R8", {31'b0, irqOut}, 32'd1);

    // R4: set beats clear on the same bit
    step(A_ST0, 1, 32'h0000_0200, EV_IO, "R4");
    step(A_ST0, 0, 0, EV_NONE, "R4");
    chk("R4", regRdData, 32'h0000_020C);

    // R3: clear only bit 9, bits 2 and 3 stay
    step(A_ST0, 1, 32'h0000_0200, EV_NONE, "R3");
    step(A_ST0, 0, 0, EV_NONE, "R3");
    chk("R3", regRdData, 32'h0000_000C);
    step(A_ST0, 1, 32'h0000_000C, EV_NONE, "R3");
    step(A_ST0, 0, 0, EV_NONE, "R3");
    chk("R3", regRdData, 32'h0000_0000);

    // R5: full-width enable storage
    step(A_EN1, 1, 32'hA5A5_5A5A, EV_NONE, "R5");
    step(A_EN1, 0, 0, EV_NONE, "R5");
    chk("R5", regRdData, 32'hA5A5_5A5A);

    // R9: revision read right after a write, then the write is visible
    step(A_EN0, 1, 32'h0000_0000, EV_NONE, "R9");
    step(A_REV, 0, 0, EV_NONE, "R9");
    chk("R9", regRdData, 32'h0001_0200);
    step(A_EN0, 0, 0, EV_NONE, "R9");
    chk("R9", regRdData, 32'h0000_0000);

    // R10: writes to revision and unused addresses change nothing
    step(A_REV, 1, 32'hFFFF_FFFF, EV_NONE, "R10");
    step(A_NONE, 1, 32'hFFFF_FFFF, EV_NONE, "R10");
    step(A_ODD, 1, 32'hFFFF_FFFF, EV_NONE, "R10");
    chk("R10", regRdData, 32'd0);
    step(A_ST1, 0, 0, EV_NONE, "R10");
    chk("R10", regRdData, 32'h0000_0001);
    step(A_EN1, 0, 0, EV_NONE, "R10");
    chk("R10", regRdData, 32'hA5A5_5A5A);

    // random phase: every cycle checked against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      logic [DATA_W-1:0] d;
      logic [3:0] ev;
      case ($urandom_range(0, 6))
        0: a = A_ST0;
        1: a = A_ST1;
        2: a = A_EN0;
        3: a = A_EN1;
        4: a = A_REV;
        5: a = A_NONE;
        default: a = A_ODD;
      endcase
      d = ($urandom_range(0, 3) == 0) ? 32'h0000_020D : $urandom();
      for (int b = 0; b < 4; b++) ev[b] = ($urandom_range(0, 3) == 0);
      step(a, $urandom_range(0, 2) == 0, d, ev, "R2");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule